// File: doc/BRIEF.md
# Stack-Based Pseudo-Code Execution Core

This block is a compact stack-machine processor that runs a subset of a classic teaching compiler's pseudo-code straight from an instruction memory. Each clock it presents a program counter, receives one 24-bit instruction word in the same cycle, and sees the two topmost 16-bit words of its expression stack. As a result, every opcode it implements retires in one cycle. A separate small return stack holds the link addresses for subroutine calls.

The harder opcodes are not executed by the core. These include multiply and divide, console and stream I/O, memory access, block copy and set handling. Instead the core raises a trap: it freezes, reports the opcode and its address, and waits for a handler to acknowledge. A halt or end-of-code opcode stops the core until the next reset.

Top module: `pstk_core`

## Requirements
- R1: While reset is asserted, the program counter and expression-stack pointer read 0, and both the halted flag and the trap request are low.
- R2: An instruction word carries the opcode in bits 23:16 and a 16-bit operand in bits 15:0. Opcodes add (0), andb (15) and orb (16) combine the word below the top with the top, store the result in place of the two words, and reduce the stack pointer by one.
- R3: Comparisons eqli (7), neqi (8), lssi (9), leqi (10), gtri (11) and geqi (12) test the word below the top against the top as signed values. Each replaces both words with 1 if the test is true and 0 if it is false.
- R4: Four opcodes rewrite the top word in place. neg (1) negates it in two's complement. div2 (5) shifts it right arithmetically by one. rem2 (6) keeps only its least significant bit. addc (38) adds the operand to it.
- R5: ldc (29) pushes the operand. dupl (13) pushes a copy of the top word. swap (14) exchanges the top two words without changing the stack pointer.
- R6: jump (40) loads the operand into the program counter. jumpz (41) pops the top word and branches to the operand only when that word is zero; otherwise it continues at the next address.
- R7: call (42) saves the next address on the return stack and jumps to the operand. exitt (45) resumes at the most recently saved address. Calls nest to the return-stack depth.
- R8: adjs (43) adds the operand, taken as a signed value, to the expression-stack pointer. Stack contents are left unchanged.
- R9: hlt (19) and stop (20) raise the halted flag. After that, the program counter and stack pointer stay fixed until reset.
- R10: Every other opcode value traps. The core raises its trap request and reports the opcode and its address, then holds all state until acknowledged. An acknowledge clears the request and moves the program counter to the next address. The trapped opcodes include 2–4, 17, 18, 21–28, 30–37, 39, 44 and all values above 45.
- R11: Each implemented opcode takes one clock. A program of k non-stopping instructions followed by hlt raises the halted flag on the (k+1)-th rising edge after reset is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| imem_addr_o | output | PC_W | Program counter, the instruction fetch address |
| imem_data_i | input | 24 | Instruction word at imem_addr_o, read in the same cycle |
| trap_ack_i | input | 1 | Handler acknowledge of a pending trap |
| trap_req_o | output | 1 | Trap pending |
| trap_op_o | output | 8 | Opcode that caused the trap |
| trap_pc_o | output | PC_W | Address of the trapping instruction |
| halted_o | output | 1 | Core stopped by hlt or stop |
| tos_o | output | 16 | Current top of the expression stack |
| sp_o | output | SP_W | Expression-stack pointer (count of words) |

## Verification
Each instruction updates the registers on the rising edge at which it is presented, so its effect on tos_o, sp_o and imem_addr_o appears after that single edge. A trap request or the halted flag is likewise visible one edge after the offending instruction is fetched, and an acknowledge takes effect one edge after it is sampled. The bench drives and samples on falling edges. It runs each short program until the core halts or traps, and it compares the edge count with the instruction count before checking the stack results. The trap sweep covers every one of the 256 opcode values.

// File: rtl/pstk_pkg.sv
package pstk_pkg;
  localparam int unsigned OP_W = 8;

  typedef enum logic [OP_W-1:0] {
    OP_ADD  = 8'd0,  OP_NEG  = 8'd1,  OP_DIV2 = 8'd5,  OP_REM2 = 8'd6,
    OP_EQ   = 8'd7,  OP_NE   = 8'd8,  OP_LT   = 8'd9,  OP_LE   = 8'd10,
    OP_GT   = 8'd11, OP_GE   = 8'd12, OP_DUP  = 8'd13, OP_SWAP = 8'd14,
    OP_AND  = 8'd15, OP_OR   = 8'd16, OP_HLT  = 8'd19, OP_STOP = 8'd20,
    OP_LDC  = 8'd29, OP_ADDC = 8'd38, OP_JMP  = 8'd40, OP_JZ   = 8'd41,
    OP_CALL = 8'd42, OP_ADJS = 8'd43, OP_EXIT = 8'd45
  } opcode_e;

  typedef enum logic [3:0] {
    FN_ADD, FN_AND, FN_OR, FN_EQ, FN_NE, FN_LT, FN_LE, FN_GT, FN_GE,
    FN_NEG, FN_DIV2, FN_REM2, FN_ADDI, FN_IMM, FN_TOS, FN_NOS
  } alu_fn_e;

  typedef enum logic [1:0] {WR_NONE, WR_TOS, WR_NOS, WR_PUSH} wr_sel_e;
  typedef enum logic [1:0] {SP_KEEP, SP_INC, SP_DEC, SP_ADJ} sp_op_e;
  typedef enum logic [1:0] {PC_SEQ, PC_JMP, PC_JZ, PC_RET} pc_op_e;

  typedef struct packed {
    alu_fn_e fn;
    wr_sel_e wr;
    logic    swap;
    sp_op_e  sp;
    pc_op_e  pc;
    logic    rs_push;
    logic    rs_pop;
    logic    halt;
    logic    trap;
  } dec_t;
endpackage

// File: rtl/pstk_decode.sv
module pstk_decode
  import pstk_pkg::*;
(
  input  logic [OP_W-1:0] op_i,
  output dec_t            dec_o
);
  always_comb begin
    dec_o      = '0;
    dec_o.fn   = FN_ADD;
    dec_o.wr   = WR_NONE;
    dec_o.sp   = SP_KEEP;
    dec_o.pc   = PC_SEQ;
    dec_o.trap = 1'b0;
    case (op_i)
      OP_ADD:  begin dec_o.fn = FN_ADD; dec_o.wr = WR_NOS; dec_o.sp = SP_DEC; end
      OP_AND:  begin dec_o.fn = FN_AND; dec_o.wr = WR_NOS; dec_o.sp = SP_DEC; end
      OP_OR:   begin dec_o.fn = FN_OR;  dec_o.wr = WR_NOS; dec_o.sp = SP_DEC; end
      OP_EQ:   begin dec_o.fn = FN_EQ;  dec_o.wr = WR_NOS; dec_o.sp = SP_DEC; end
      OP_NE:   begin dec_o.fn = FN_NE;  dec_o.wr = WR_NOS; dec_o.sp = SP_DEC; end
      OP_LT:   begin dec_o.fn = FN_LT;  dec_o.wr = WR_NOS; dec_o.sp = SP_DEC; end
      OP_LE:   begin dec_o.fn = FN_LE;  dec_o.wr = WR_NOS; dec_o.sp = SP_DEC; end
      OP_GT:   begin dec_o.fn = FN_GT;  dec_o.wr = WR_NOS; dec_o.sp = SP_DEC; end
      OP_GE:   begin dec_o.fn = FN_GE;  dec_o.wr = WR_NOS; dec_o.sp = SP_DEC; end
      OP_NEG:  begin dec_o.fn = FN_NEG;  dec_o.wr = WR_TOS; end
      OP_DIV2: begin dec_o.fn = FN_DIV2; dec_o.wr = WR_TOS; end
      OP_REM2: begin dec_o.fn = FN_REM2; dec_o.wr = WR_TOS; end
      OP_ADDC: begin dec_o.fn = FN_ADDI; dec_o.wr = WR_TOS; end
      OP_DUP:  begin dec_o.fn = FN_TOS; dec_o.wr = WR_PUSH; dec_o.sp = SP_INC; end
      OP_LDC:  begin dec_o.fn = FN_IMM; dec_o.wr = WR_PUSH; dec_o.sp = SP_INC; end
      // swap: port A puts nos on top, port B puts tos below
      OP_SWAP: begin dec_o.fn = FN_NOS; dec_o.wr = WR_TOS; dec_o.swap = 1'b1; end
      OP_JMP:  dec_o.pc = PC_JMP;
      OP_JZ:   begin dec_o.pc = PC_JZ; dec_o.sp = SP_DEC; end
      OP_CALL: begin dec_o.pc = PC_JMP; dec_o.rs_push = 1'b1; end
      OP_EXIT: begin dec_o.pc = PC_RET; dec_o.rs_pop = 1'b1; end
      OP_ADJS: dec_o.sp = SP_ADJ;
      OP_HLT, OP_STOP: dec_o.halt = 1'b1;
      default: dec_o.trap = 1'b1;
    endcase
  end
endmodule

// File: rtl/pstk_alu.sv
module pstk_alu
  import pstk_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  alu_fn_e           fn_i,
  input  logic [DATA_W-1:0] tos_i,
  input  logic [DATA_W-1:0] nos_i,
  input  logic [DATA_W-1:0] imm_i,
  output logic [DATA_W-1:0] res_o
);
  logic signed [DATA_W-1:0] s_tos, s_nos;
  assign s_tos = $signed(tos_i);
  assign s_nos = $signed(nos_i);

  always_comb begin
    case (fn_i)
      FN_ADD:  res_o = nos_i + tos_i;
      FN_AND:  res_o = nos_i & tos_i;
      FN_OR:   res_o = nos_i | tos_i;
      FN_EQ:   res_o = DATA_W'(nos_i == tos_i);
      FN_NE:   res_o = DATA_W'(nos_i != tos_i);
      FN_LT:   res_o = DATA_W'(s_nos <  s_tos);
      FN_LE:   res_o = DATA_W'(s_nos <= s_tos);
      FN_GT:   res_o = DATA_W'(s_nos >  s_tos);
      FN_GE:   res_o = DATA_W'(s_nos >= s_tos);
      FN_NEG:  res_o = '0 - tos_i;
      FN_DIV2: res_o = DATA_W'(s_tos >>> 1);
      FN_REM2: res_o = DATA_W'(tos_i[0]);
      FN_ADDI: res_o = tos_i + imm_i;
      FN_IMM:  res_o = imm_i;
      FN_TOS:  res_o = tos_i;
      FN_NOS:  res_o = nos_i;
      default: res_o = '0;
    endcase
  end
endmodule

// File: rtl/pstk_estack.sv
module pstk_estack #(
  parameter  int unsigned DATA_W = 16,
  parameter  int unsigned DEPTH  = 16,
  localparam int unsigned AW     = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [AW-1:0]     sp_i,
  input  logic              we_a_i,
  input  logic [AW-1:0]     wa_a_i,
  input  logic [DATA_W-1:0] wd_a_i,
  input  logic              we_b_i,
  input  logic [AW-1:0]     wa_b_i,
  input  logic [DATA_W-1:0] wd_b_i,
  output logic [DATA_W-1:0] tos_o,
  output logic [DATA_W-1:0] nos_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_row
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) mem_q[g] <= '0;
      else if (we_a_i && wa_a_i == AW'(g)) mem_q[g] <= wd_a_i;
      else if (we_b_i && wa_b_i == AW'(g)) mem_q[g] <= wd_b_i;
    end
  end

  assign tos_o = mem_q[sp_i - AW'(1)];
  assign nos_o = mem_q[sp_i - AW'(2)];
endmodule

// File: rtl/pstk_rstack.sv
module pstk_rstack #(
  parameter  int unsigned PC_W  = 16,
  parameter  int unsigned DEPTH = 8,
  localparam int unsigned AW    = $clog2(DEPTH)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            push_i,
  input  logic            pop_i,
  input  logic [PC_W-1:0] push_data_i,
  output logic [PC_W-1:0] top_o
);
  logic [PC_W-1:0] mem_q [DEPTH];
  logic [AW-1:0]   ptr_q;

  for (genvar g = 0; g < DEPTH; g++) begin : g_row
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) mem_q[g] <= '0;
      else if (push_i && ptr_q == AW'(g)) mem_q[g] <= push_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ptr_q <= '0;
    else if (push_i) ptr_q <= ptr_q + AW'(1);
    else if (pop_i)  ptr_q <= ptr_q - AW'(1);
  end

  assign top_o = mem_q[ptr_q - AW'(1)];
endmodule

// File: rtl/pstk_core.sv
module pstk_core
  import pstk_pkg::*;
#(
  parameter  int unsigned DATA_W   = 16,
  parameter  int unsigned PC_W     = 16,
  parameter  int unsigned ES_DEPTH = 16,
  parameter  int unsigned RS_DEPTH = 8,
  localparam int unsigned INSTR_W  = OP_W + DATA_W,
  localparam int unsigned SP_W     = $clog2(ES_DEPTH)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  output logic [PC_W-1:0]    imem_addr_o,
  input  logic [INSTR_W-1:0] imem_data_i,
  input  logic               trap_ack_i,
  output logic               trap_req_o,
  output logic [OP_W-1:0]    trap_op_o,
  output logic [PC_W-1:0]    trap_pc_o,
  output logic               halted_o,
  output logic [DATA_W-1:0]  tos_o,
  output logic [SP_W-1:0]    sp_o
);
  logic [PC_W-1:0]   pc_q, pc_inc, pc_tgt, pc_next, rs_top;
  logic [SP_W-1:0]   sp_q, sp_next, wa_a;
  logic              halted_q, trap_q, run, exec;
  logic [OP_W-1:0]   trap_op_q, op;
  logic [PC_W-1:0]   trap_pc_q;
  logic [DATA_W-1:0] imm, tos, nos, res;
  dec_t              dec;

  assign op     = imem_data_i[INSTR_W-1:DATA_W];
  assign imm    = imem_data_i[DATA_W-1:0];
  assign run    = !halted_q && !trap_q;
  assign exec   = run && !dec.trap && !dec.halt;
  assign pc_inc = pc_q + PC_W'(1);
  assign pc_tgt = PC_W'(imm);

  pstk_decode u_dec (.op_i(op), .dec_o(dec));

  pstk_alu #(.DATA_W(DATA_W)) u_alu (
    .fn_i(dec.fn), .tos_i(tos), .nos_i(nos), .imm_i(imm), .res_o(res)
  );

  always_comb begin
    case (dec.wr)
      WR_NOS:  wa_a = sp_q - SP_W'(2);
      WR_PUSH: wa_a = sp_q;
      default: wa_a = sp_q - SP_W'(1);
    endcase
  end

  pstk_estack #(.DATA_W(DATA_W), .DEPTH(ES_DEPTH)) u_es (
    .clk_i (clk_i), .rst_ni(rst_ni), .sp_i(sp_q),
    .we_a_i(exec && dec.wr != WR_NONE), .wa_a_i(wa_a), .wd_a_i(res),
    .we_b_i(exec && dec.swap), .wa_b_i(sp_q - SP_W'(2)), .wd_b_i(tos),
    .tos_o (tos), .nos_o(nos)
  );

  pstk_rstack #(.PC_W(PC_W), .DEPTH(RS_DEPTH)) u_rs (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .push_i(exec && dec.rs_push), .pop_i(exec && dec.rs_pop),
    .push_data_i(pc_inc), .top_o(rs_top)
  );

  always_comb begin
    case (dec.pc)
      PC_JMP:  pc_next = pc_tgt;
      PC_JZ:   pc_next = (tos == '0) ? pc_tgt : pc_inc;
      PC_RET:  pc_next = rs_top;
      default: pc_next = pc_inc;
    endcase
    case (dec.sp)
      SP_INC:  sp_next = sp_q + SP_W'(1);
      SP_DEC:  sp_next = sp_q - SP_W'(1);
      SP_ADJ:  sp_next = sp_q + SP_W'(imm);  // two's complement wrap
      default: sp_next = sp_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q      <= '0;
      sp_q      <= '0;
      halted_q  <= 1'b0;
      trap_q    <= 1'b0;
      trap_op_q <= '0;
      trap_pc_q <= '0;
    end else if (trap_q) begin
      if (trap_ack_i) begin
        trap_q <= 1'b0;
        pc_q   <= pc_inc;
      end
    end else if (!halted_q) begin
      if (dec.trap) begin
        trap_q    <= 1'b1;
        trap_op_q <= op;
        trap_pc_q <= pc_q;
      end else if (dec.halt) begin
        halted_q <= 1'b1;
      end else begin
        pc_q <= pc_next;
        sp_q <= sp_next;
      end
    end
  end

  assign imem_addr_o = pc_q;
  assign trap_req_o  = trap_q;
  assign trap_op_o   = trap_op_q;
  assign trap_pc_o   = trap_pc_q;
  assign halted_o    = halted_q;
  assign tos_o       = tos;
  assign sp_o        = sp_q;
endmodule

// File: rtl/pstk_core_chk.sv
module pstk_core_chk #(
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned PC_W    = 16,
  parameter int unsigned SP_W    = 4,
  parameter int unsigned INSTR_W = 24
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [PC_W-1:0]    imem_addr_o,
  input logic [INSTR_W-1:0] imem_data_i,
  input logic               trap_ack_i,
  input logic               trap_req_o,
  input logic [7:0]         trap_op_o,
  input logic [PC_W-1:0]    trap_pc_o,
  input logic               halted_o,
  input logic [SP_W-1:0]    sp_o
);
  logic [7:0] op;
  logic       run;
  logic       seen_rst_q;
  assign op  = imem_data_i[INSTR_W-1:DATA_W];
  assign run = !halted_o && !trap_req_o;

  always_ff @(posedge clk_i) seen_rst_q <= !rst_ni;

  always @(posedge clk_i)
    if (!rst_ni && seen_rst_q)
      assert_reset_state_R1: assert (imem_addr_o == '0 && sp_o == '0 && !halted_o && !trap_req_o);

  assert_add_pop_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run && op == 8'd0 |=> sp_o == $past(sp_o) - SP_W'(1));

  assert_ldc_push_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run && op == 8'd29 |=> sp_o == $past(sp_o) + SP_W'(1));

  assert_jump_target_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run && op == 8'd40 |=> imem_addr_o == PC_W'($past(imem_data_i[DATA_W-1:0])));

  assert_halt_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |=> halted_o && $stable(imem_addr_o) && $stable(sp_o));

  assert_trap_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_req_o && !trap_ack_i |=> trap_req_o && $stable(trap_op_o) && $stable(trap_pc_o)
                                  && $stable(imem_addr_o) && $stable(sp_o));

  assert_trap_ack_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_req_o && trap_ack_i |=> !trap_req_o && imem_addr_o == $past(imem_addr_o) + PC_W'(1));

  assert_no_halt_trap_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(halted_o && trap_req_o));

  assert_single_cycle_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run && op == 8'd29 |=> imem_addr_o == $past(imem_addr_o) + PC_W'(1));
endmodule

bind pstk_core pstk_core_chk #(
  .DATA_W(DATA_W), .PC_W(PC_W), .SP_W(SP_W), .INSTR_W(INSTR_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .imem_addr_o(imem_addr_o), .imem_data_i(imem_data_i),
  .trap_ack_i(trap_ack_i), .trap_req_o(trap_req_o), .trap_op_o(trap_op_o),
  .trap_pc_o(trap_pc_o), .halted_o(halted_o), .sp_o(sp_o)
);

// File: tb/pstk_core_tb.sv
module pstk_core_tb;
  localparam int CLK_P = 10;

  logic        clk_i = 1'b0, rst_ni = 1'b1, trap_ack_i = 1'b0;
  logic [15:0] imem_addr_o, trap_pc_o, tos_o;
  logic [23:0] imem_data_i;
  logic [7:0]  trap_op_o;
  logic [3:0]  sp_o;
  logic        trap_req_o, halted_o;
  logic [23:0] prog [64];
  int          errors = 0, checks = 0;
  bit          done = 1'b0;

  always #(CLK_P/2) clk_i = ~clk_i;
  assign imem_data_i = prog[imem_addr_o[5:0]];

  pstk_core u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .imem_addr_o(imem_addr_o), .imem_data_i(imem_data_i),
    .trap_ack_i(trap_ack_i), .trap_req_o(trap_req_o), .trap_op_o(trap_op_o),
    .trap_pc_o(trap_pc_o), .halted_o(halted_o), .tos_o(tos_o), .sp_o(sp_o)
  );

  localparam logic [15:0] VALS [8] = '{16'h0000, 16'h0001, 16'hFFFF, 16'h0005,
                                       16'hFFFB, 16'h7FFF, 16'h8000, 16'h0003};

  function automatic logic [23:0] ins(int op, int imm);
    return {8'(op), 16'(imm)};
  endfunction

  function automatic bit implemented(int c);
    return c == 0 || c == 1 || (c >= 5 && c <= 16) || c == 19 || c == 20 || c == 29 ||
           c == 38 || (c >= 40 && c <= 43) || c == 45;
  endfunction

  function automatic logic [15:0] exp_bin(int op, logic [15:0] n, logic [15:0] t);
    case (op)
      0:  return n + t;
      15: return n & t;
      16: return n | t;
      7:  return 16'(n == t);
      8:  return 16'(n != t);
      9:  return 16'($signed(n) <  $signed(t));
      10: return 16'($signed(n) <= $signed(t));
      11: return 16'($signed(n) >  $signed(t));
      default: return 16'($signed(n) >= $signed(t));
    endcase
  endfunction

  function automatic logic [15:0] exp_un(int op, logic [15:0] v, logic [15:0] c);
    case (op)
      1:  return 16'(0) - v;
      5:  return {v[15], v[15:1]};
      6:  return {15'd0, v[0]};
      default: return v + c;
    endcase
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_prog();
    for (int i = 0; i < 64; i++) prog[i] = ins(19, 0);
  endtask

  task automatic run(output int cyc);
    @(negedge clk_i); rst_ni = 1'b0;
    @(negedge clk_i); rst_ni = 1'b1;
    cyc = 0;
    while (!halted_o && !trap_req_o && cyc < 100) begin
      @(negedge clk_i); cyc++;
    end
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int cyc;
    clear_prog();
    #1 rst_ni = 1'b0;
    @(negedge clk_i); @(negedge clk_i);
    // R1 reset state
    chk("R1 pc", int'(imem_addr_o), 0);
    chk("R1 sp", int'(sp_o), 0);
    chk("R1 halted", int'(halted_o), 0);
    chk("R1 trap", int'(trap_req_o), 0);

    // R2 R3 R11 binary sweep
    foreach (VALS[i]) foreach (VALS[j]) begin
      int bops[9] = '{0, 15, 16, 7, 8, 9, 10, 11, 12};
      foreach (bops[k]) begin
        clear_prog();
        prog[0] = ins(29, VALS[i]); prog[1] = ins(29, VALS[j]); prog[2] = ins(bops[k], 0);
        run(cyc);
        chk((bops[k] <= 16 && bops[k] >= 7 && bops[k] <= 12) ? "R3 compare" : "R2 binary",
            int'(tos_o), int'(exp_bin(bops[k], VALS[i], VALS[j])));
        chk("R2 sp after pop", int'(sp_o), 1);
        chk("R11 cycles", cyc, 4);
      end
    end

    // R4 unary sweep
    foreach (VALS[i]) foreach (VALS[j]) begin
      int uops[4] = '{1, 5, 6, 38};
      foreach (uops[k]) begin
        clear_prog();
        prog[0] = ins(29, VALS[i]); prog[1] = ins(uops[k], VALS[j]);
        run(cyc);
        chk("R4 unary", int'(tos_o), int'(exp_un(uops[k], VALS[i], VALS[j])));
        chk("R4 sp", int'(sp_o), 1);
      end
    end

    // R5 swap, dupl
    clear_prog();
    prog[0] = ins(29, 11); prog[1] = ins(29, 22); prog[2] = ins(14, 0);
    run(cyc);
    chk("R5 swap top", int'(tos_o), 11);
    chk("R5 swap sp", int'(sp_o), 2);
    prog[3] = ins(43, -1);
    run(cyc);
    chk("R5 swap below", int'(tos_o), 22);
    clear_prog();
    prog[0] = ins(29, 9); prog[1] = ins(13, 0);
    run(cyc);
    chk("R5 dupl sp", int'(sp_o), 2);
    prog[2] = ins(0, 0);
    run(cyc);
    chk("R5 dupl sum", int'(tos_o), 18);

    // R6 jump / jumpz
    clear_prog();
    prog[0] = ins(29, 1); prog[1] = ins(40, 4); prog[2] = ins(29, 99); prog[4] = ins(29, 7);
    run(cyc);
    chk("R6 jump tos", int'(tos_o), 7);
    chk("R6 jump pc", int'(imem_addr_o), 5);
    chk("R6 jump sp", int'(sp_o), 2);
    prog[0] = ins(29, 0); prog[1] = ins(41, 4);
    run(cyc);
    chk("R6 jumpz taken tos", int'(tos_o), 7);
    chk("R6 jumpz taken sp", int'(sp_o), 1);
    prog[0] = ins(29, 3);
    run(cyc);
    chk("R6 jumpz fall tos", int'(tos_o), 99);
    chk("R6 jumpz fall pc", int'(imem_addr_o), 3);

    // R7 nested call / return
    clear_prog();
    prog[0] = ins(42, 5); prog[1] = ins(29, 2); prog[5] = ins(29, 1);
    prog[6] = ins(42, 10); prog[7] = ins(45, 0); prog[10] = ins(29, 3); prog[11] = ins(45, 0);
    run(cyc);
    chk("R7 tos", int'(tos_o), 2);
    chk("R7 sp", int'(sp_o), 3);
    chk("R7 pc", int'(imem_addr_o), 2);
    chk("R7 cycles", cyc, 8);

    // R8 adjs
    clear_prog();
    prog[0] = ins(29, 10); prog[1] = ins(29, 20); prog[2] = ins(29, 30); prog[3] = ins(43, -2);
    run(cyc);
    chk("R8 adjs down sp", int'(sp_o), 1);
    chk("R8 adjs down tos", int'(tos_o), 10);
    prog[3] = ins(43, -1); prog[4] = ins(43, 1);
    run(cyc);
    chk("R8 adjs restore tos", int'(tos_o), 30);

    // R9 stop freezes
    clear_prog();
    prog[0] = ins(29, 4); prog[1] = ins(20, 0); prog[2] = ins(29, 5);
    run(cyc);
    chk("R9 halted", int'(halted_o), 1);
    chk("R11 stop cycles", cyc, 2);
    repeat (5) @(negedge clk_i);
    chk("R9 pc frozen", int'(imem_addr_o), 1);
    chk("R9 sp frozen", int'(sp_o), 1);
    chk("R9 tos frozen", int'(tos_o), 4);

    // R10 trap sweep over all opcode values
    for (int c = 0; c < 256; c++) begin
      if (implemented(c)) continue;
      clear_prog();
      prog[0] = ins(29, 5); prog[1] = ins(c, 0);
      run(cyc);
      chk("R10 trap req", int'(trap_req_o), 1);
      chk("R10 trap op", int'(trap_op_o), c);
      chk("R10 trap pc", int'(trap_pc_o), 1);
      chk("R10 trap cycles", cyc, 2);
      repeat (3) @(negedge clk_i);
      chk("R10 held pc", int'(imem_addr_o), 1);
      chk("R10 held sp", int'(sp_o), 1);
      trap_ack_i = 1'b1;
      @(negedge clk_i);
      trap_ack_i = 1'b0;
      chk("R10 ack clears", int'(trap_req_o), 0);
      chk("R10 ack pc", int'(imem_addr_o), 2);
      @(negedge clk_i);
      chk("R10 resume halts", int'(halted_o), 1);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule